// File: doc/BRIEF.md
# Paired-Byte ISA to IDE Port Bridge

This block sits between an 8-bit ISA-style host bus and a 16-bit IDE task file. It decodes a 32-port I/O window and an 8 KB option-ROM window. The I/O base and the ROM base are each chosen by a 4-bit switch value. The lower 16 ports of the I/O window reach the task-file registers one byte at a time, as older driver code expects. In the upper 16 ports, every access goes to the drive's data register. A phase bit alternates between the low and the high half of the 16-bit word on each access.

A CPU with an 8-bit bus splits a word I/O instruction at port N into two byte cycles: first at N, then at N+1, with no other bus cycle between them. With this block, that pair moves one complete drive word. On reads, the first byte cycle runs the drive read and keeps the high byte for the second cycle. On writes, the first byte is held until the second byte arrives, and then one drive write carries both. Any lower-window access sets the phase back to low, so a driver can always realign the pairing.

The bus strobes `ior`, `iow` and `memr` are single-cycle requests, sampled on the rising edge. They are mutually exclusive, and `ior` wins if `ior` and `iow` are both high. There is no back-pressure: each strobe completes in its own cycle. The drive strobes, selects, address and data paths follow the inputs combinationally in that same cycle. The phase bit and the two byte holders update at the edge that ends the cycle.

Top module: `ide_pair_bridge`

## Requirements
- R1: An I/O cycle hits the window when A19:A10 are all 0, A9 is 1 and A8:A5 equal `io_sw`. A4=0 selects the legacy half and A4=1 selects the paired half. Every other I/O address is a miss.
- R2: A legacy access drives `drv_addr`=A2:A0, with `drv_cs0` when A3=0 and `drv_cs1` when A3=1, and issues one drive strobe. A read returns `drv_rdata[7:0]`. A write drives `drv_wdata`={8'h00, `host_wdata`}.
- R3: Any paired-half access presents register 0 on `drv_cs0` (`drv_addr`=0, `drv_cs1`=0), whatever A3:A0 are.
- R4: Reset puts the phase in the low state. Each paired-half read or write flips the phase.
- R5: Any legacy-half read or write returns the phase to the low state.
- R6: A low-phase paired read pulses `drv_rd` once and returns `drv_rdata[7:0]`, and the block keeps `drv_rdata[15:8]`. A high-phase paired read returns the kept byte and issues no `drv_rd`.
- R7: A low-phase paired write only stores `host_wdata` and issues no `drv_wr`. A high-phase paired write pulses `drv_wr` once with `drv_wdata`={`host_wdata`, stored byte}.
- R8: `rom_ce` is high when `memr` is high, A19 and A18 are 1, A13 is 0 and A17:A14 equal `rom_sw`. A memory read never produces a drive strobe or chip select.
- R9: A cycle outside both windows, or an idle cycle, drives every drive strobe and select low, and drives `host_rdata`, `drv_addr` and `drv_wdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Host address bus |
| ior | input | 1 | I/O read strobe, one cycle |
| iow | input | 1 | I/O write strobe, one cycle |
| memr | input | 1 | Memory read strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned to host |
| io_sw | input | 4 | I/O base switch value (A8:A5) |
| rom_sw | input | 4 | ROM base switch value (A17:A14) |
| drv_addr | output | 3 | Drive register address |
| drv_cs0 | output | 1 | Drive command-block select |
| drv_cs1 | output | 1 | Drive control-block select |
| drv_rd | output | 1 | Drive read strobe |
| drv_wr | output | 1 | Drive write strobe |
| drv_wdata | output | 16 | Word driven to drive |
| drv_rdata | input | 16 | Word read from drive |
| rom_ce | output | 1 | Option-ROM chip enable |

## Verification
The bench sweeps every one of the 1024 I/O port addresses as reads under each of the 16 switch values. Because the phase carries over between consecutive paired reads, this sweep separates true window hits from near misses on each address bit, and it also exercises the alternation of low and high reads. A second sweep covers every ROM base against every combination of A19:A13. It tells the window apart from addresses one switch step off or with A13 set, and it shows that memory reads leave the drive untouched. Write pairs over all byte values check that both bytes land in the correct half of the word. Short directed sequences check that a legacy access between paired accesses realigns the phase, and that addresses with upper bits set are ignored.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  // Region a bus cycle falls into
  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_LEGACY = 2'd1,
    RGN_PAIRED = 2'd2,
    RGN_ROM    = 2'd3
  } region_e;

  localparam int HOST_W = 8;
  localparam int REG_W  = 3;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode #(
  parameter int ADDR_W       = 20,
  parameter int SW_W         = 4,
  parameter int IO_BASE_BIT  = 5,
  parameter int ROM_BASE_BIT = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SW_W-1:0]   io_sw,
  input  logic [SW_W-1:0]   rom_sw,
  output logic              io_lo_hit,
  output logic              io_hi_hit,
  output logic              rom_hit
);
  localparam int IO_TOP  = IO_BASE_BIT + SW_W;   // fixed-one port bit
  localparam int ROM_TOP = ROM_BASE_BIT + SW_W;  // lowest all-ones bit

  logic io_win;
  logic upper_zero;

  // upper port bits must be idle; A(IO_TOP) set; switch match
  assign upper_zero = (addr[ADDR_W-1:IO_TOP+1] == '0);
  assign io_win     = upper_zero && addr[IO_TOP] &&
                      (addr[IO_TOP-1:IO_BASE_BIT] == io_sw);
  assign io_lo_hit  = io_win && !addr[IO_BASE_BIT-1];
  assign io_hi_hit  = io_win &&  addr[IO_BASE_BIT-1];

  assign rom_hit = (&addr[ADDR_W-1:ROM_TOP]) &&
                   !addr[ROM_BASE_BIT-1] &&
                   (addr[ROM_TOP-1:ROM_BASE_BIT] == rom_sw);
endmodule

// File: rtl/ide_pair_ctrl.sv
module ide_pair_ctrl #(
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_acc,     // paired-half access this cycle
  input  logic              lo_acc,     // legacy-half access this cycle
  input  logic              rd_first,   // low-phase paired read
  input  logic              wr_first,   // low-phase paired write
  input  logic [HOST_W-1:0] drv_hi_in,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              phase_hi,
  output logic [HOST_W-1:0] rd_keep,
  output logic [HOST_W-1:0] wr_keep
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_hi <= 1'b0;
      rd_keep  <= '0;
      wr_keep  <= '0;
    end else begin
      if (lo_acc)      phase_hi <= 1'b0;
      else if (hi_acc) phase_hi <= !phase_hi;
      if (rd_first) rd_keep <= drv_hi_in;
      if (wr_first) wr_keep <= host_wdata;
    end
  end
endmodule

// File: rtl/ide_datapath.sv
module ide_datapath
  import ide_bridge_pkg::*;
#(
  parameter int HOST_W = 8
) (
  input  region_e             rgn,
  input  logic                rd_cyc,
  input  logic                wr_cyc,
  input  logic                phase_hi,
  input  logic [3:0]          port_lo,
  input  logic [HOST_W-1:0]   host_wdata,
  input  logic [2*HOST_W-1:0] drv_rdata,
  input  logic [HOST_W-1:0]   rd_keep,
  input  logic [HOST_W-1:0]   wr_keep,
  output logic [HOST_W-1:0]   host_rdata,
  output logic [REG_W-1:0]    drv_addr,
  output logic                drv_cs0,
  output logic                drv_cs1,
  output logic                drv_rd,
  output logic                drv_wr,
  output logic [2*HOST_W-1:0] drv_wdata
);
  logic leg, par;
  assign leg = (rgn == RGN_LEGACY) && (rd_cyc || wr_cyc);
  assign par = (rgn == RGN_PAIRED) && (rd_cyc || wr_cyc);

  always_comb begin
    host_rdata = '0;
    drv_addr   = '0;
    drv_cs0    = 1'b0;
    drv_cs1    = 1'b0;
    drv_rd     = 1'b0;
    drv_wr     = 1'b0;
    drv_wdata  = '0;
    if (leg) begin
      drv_addr = port_lo[REG_W-1:0];
      drv_cs0  = !port_lo[3];
      drv_cs1  = port_lo[3];
      if (rd_cyc) begin
        drv_rd     = 1'b1;
        host_rdata = drv_rdata[HOST_W-1:0];
      end else begin
        drv_wr    = 1'b1;
        drv_wdata = {{HOST_W{1'b0}}, host_wdata};
      end
    end else if (par) begin
      drv_cs0 = 1'b1;
      if (rd_cyc) begin
        if (!phase_hi) begin
          drv_rd     = 1'b1;
          host_rdata = drv_rdata[HOST_W-1:0];
        end else begin
          host_rdata = rd_keep;
        end
      end else if (phase_hi) begin
        drv_wr    = 1'b1;
        drv_wdata = {host_wdata, wr_keep};
      end
    end
  end
endmodule

// File: rtl/ide_pair_bridge.sv
module ide_pair_bridge
  import ide_bridge_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SW_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ior,
  input  logic                iow,
  input  logic                memr,
  input  logic [HOST_W-1:0]   host_wdata,
  output logic [HOST_W-1:0]   host_rdata,
  input  logic [SW_W-1:0]     io_sw,
  input  logic [SW_W-1:0]     rom_sw,
  output logic [REG_W-1:0]    drv_addr,
  output logic                drv_cs0,
  output logic                drv_cs1,
  output logic                drv_rd,
  output logic                drv_wr,
  output logic [2*HOST_W-1:0] drv_wdata,
  input  logic [2*HOST_W-1:0] drv_rdata,
  output logic                rom_ce
);
  logic io_lo_hit, io_hi_hit, rom_hit;
  logic rd_cyc, wr_cyc, lo_acc, hi_acc, phase_hi;
  logic [HOST_W-1:0] rd_keep, wr_keep;
  region_e rgn;

  ide_addr_decode #(.ADDR_W(ADDR_W), .SW_W(SW_W)) u_dec (
    .addr(addr), .io_sw(io_sw), .rom_sw(rom_sw),
    .io_lo_hit(io_lo_hit), .io_hi_hit(io_hi_hit), .rom_hit(rom_hit)
  );

  assign rd_cyc = ior;
  assign wr_cyc = iow && !ior;
  assign lo_acc = io_lo_hit && (rd_cyc || wr_cyc);
  assign hi_acc = io_hi_hit && (rd_cyc || wr_cyc);

  always_comb begin
    if (io_lo_hit)      rgn = RGN_LEGACY;
    else if (io_hi_hit) rgn = RGN_PAIRED;
    else if (rom_hit)   rgn = RGN_ROM;
    else                rgn = RGN_NONE;
  end

  ide_pair_ctrl #(.HOST_W(HOST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hi_acc(hi_acc), .lo_acc(lo_acc),
    .rd_first(hi_acc && rd_cyc && !phase_hi),
    .wr_first(hi_acc && wr_cyc && !phase_hi),
    .drv_hi_in(drv_rdata[2*HOST_W-1:HOST_W]), .host_wdata(host_wdata),
    .phase_hi(phase_hi), .rd_keep(rd_keep), .wr_keep(wr_keep)
  );

  ide_datapath #(.HOST_W(HOST_W)) u_dp (
    .rgn(rgn), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .phase_hi(phase_hi),
    .port_lo(addr[3:0]), .host_wdata(host_wdata), .drv_rdata(drv_rdata),
    .rd_keep(rd_keep), .wr_keep(wr_keep), .host_rdata(host_rdata),
    .drv_addr(drv_addr), .drv_cs0(drv_cs0), .drv_cs1(drv_cs1),
    .drv_rd(drv_rd), .drv_wr(drv_wr), .drv_wdata(drv_wdata)
  );

  assign rom_ce = memr && rom_hit;
endmodule

// File: rtl/ide_pair_bridge_chk.sv
module ide_pair_bridge_chk #(
  parameter int ADDR_W = 20,
  parameter int SW_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ior,
  input logic              iow,
  input logic              memr,
  input logic [SW_W-1:0]   io_sw,
  input logic [2:0]        drv_addr,
  input logic              drv_cs0,
  input logic              drv_cs1,
  input logic              drv_rd,
  input logic              drv_wr,
  input logic              phase_hi
);
  localparam int IO_TOP = 5 + SW_W;
  logic win, up_acc, dn_acc;
  assign win    = (addr[ADDR_W-1:IO_TOP+1] == '0) && addr[IO_TOP] &&
                  (addr[IO_TOP-1:5] == io_sw);
  assign up_acc = win && addr[4] && (ior || iow);
  assign dn_acc = win && !addr[4] && (ior || iow);

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    up_acc |=> phase_hi != $past(phase_hi)); // R4
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dn_acc |=> !phase_hi); // R5
  AST_PAIR_REG0: assert property (@(posedge clk) disable iff (!rst_n)
    up_acc |-> (drv_addr == 3'd0) && drv_cs0 && !drv_cs1); // R3
  AST_NO_SECOND_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (up_acc && ior && phase_hi) |-> !drv_rd); // R6
  AST_WRITE_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (up_acc && iow && !ior) |-> (drv_wr == phase_hi)); // R7
  AST_ROM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (memr && !ior && !iow) |-> !drv_rd && !drv_wr && !drv_cs0 && !drv_cs1); // R8
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> !drv_rd && !drv_wr && $onehot0({drv_cs0, drv_cs1}) && !drv_cs0); // R9
endmodule

bind ide_pair_bridge ide_pair_bridge_chk #(.ADDR_W(ADDR_W), .SW_W(SW_W)) chk (.*);

// File: tb/ide_pair_bridge_test.sv
`timescale 1ns/1ps
module ide_pair_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic ior = 1'b0, iow = 1'b0, memr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [3:0] io_sw = 4'h8, rom_sw = 4'h2;
  logic [2:0] drv_addr;
  logic drv_cs0, drv_cs1, drv_rd, drv_wr, rom_ce;
  logic [15:0] drv_wdata, drv_rdata = '0;

  int vectors = 0, errors = 0;
  logic m_ph = 1'b0;
  logic [7:0] m_hi = '0, m_lo = '0;
  bit done = 0;

  always #10 clk = !clk;

  ide_pair_bridge uut (.*);

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // kind: 0 = I/O read, 1 = I/O write, 2 = memory read, 3 = idle
  task automatic xfer(input int kind, input logic [19:0] a, input logic [7:0] wd,
                      input logic [15:0] rd, input string tag);
    logic [31:0] e, g;
    logic hit, lo, hi, romh;
    logic e_rd, e_wr, e_c0, e_c1, e_rom;
    logic [2:0] e_a; logic [7:0] e_rdat; logic [15:0] e_wdat;
    @(negedge clk);
    addr = a; ior = (kind == 0); iow = (kind == 1); memr = (kind == 2);
    host_wdata = wd; drv_rdata = rd;
    hit  = (a[19:10] == 0) && a[9] && (((a >> 5) & 20'hF) == io_sw) && (kind < 2);
    lo   = hit && !a[4];
    hi   = hit && a[4];
    romh = (kind == 2) && a[19] && a[18] && !a[13] && (((a >> 14) & 20'hF) == rom_sw);
    e_rd = 0; e_wr = 0; e_c0 = 0; e_c1 = 0; e_a = 0; e_rdat = 0; e_wdat = 0;
    e_rom = romh;
    if (lo) begin
      e_a = a[2:0]; e_c0 = !a[3]; e_c1 = a[3];
      if (kind == 0) begin e_rd = 1; e_rdat = rd[7:0]; end
      else begin e_wr = 1; e_wdat = {8'h00, wd}; end
    end else if (hi) begin
      e_c0 = 1;
      if (kind == 0) begin
        if (!m_ph) begin e_rd = 1; e_rdat = rd[7:0]; end else e_rdat = m_hi;
      end else if (m_ph) begin
        e_wr = 1; e_wdat = {wd, m_lo};
      end
    end
    #5;
    e = {e_rd, e_wr, e_c0, e_c1, e_a, e_rom, e_rdat, e_wdat};
    g = {drv_rd, drv_wr, drv_cs0, drv_cs1, drv_addr, rom_ce, host_rdata, drv_wdata};
    vectors++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s addr=%h kind=%0d: got %h expected %h", tag, a, kind, g, e);
    end
    @(posedge clk); #1;
    ior = 0; iow = 0; memr = 0;
    if (lo) m_ph = 0;
    else if (hi) begin
      if (!m_ph && kind == 0) m_hi = rd[15:8];
      if (!m_ph && kind == 1) m_lo = wd;
      m_ph = !m_ph;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 / R4: idle after reset is quiet
    xfer(3, 20'h00300, 8'h00, 16'hFFFF, "R9");
    // R4: first paired read after reset is a low-phase read
    xfer(0, 20'h00310, 8'h00, 16'hBEEF, "R4");
    xfer(0, 20'h00311, 8'h00, 16'h0000, "R6");
    // R3: paired addresses ignore A3:A0
    xfer(0, 20'h0031F, 8'h00, 16'h1234, "R3");
    xfer(0, 20'h0031A, 8'h00, 16'h5678, "R3");
    // R5: legacy access between halves realigns
    xfer(0, 20'h00310, 8'h00, 16'hA1B2, "R5");
    xfer(1, 20'h00307, 8'h44, 16'h0000, "R5");
    xfer(0, 20'h00310, 8'h00, 16'hC3D4, "R5");
    xfer(0, 20'h00311, 8'h00, 16'h0000, "R6");
    // R9: upper address bits set must miss
    xfer(0, 20'h01310, 8'h00, 16'h1111, "R9");
    xfer(1, 20'h80300, 8'h22, 16'h0000, "R9");
    // R2: legacy register map, both selects
    for (int p = 0; p < 16; p++) begin
      xfer(0, 20'h00300 | p, 8'h00, 16'h9A00 | p, "R2");
      xfer(1, 20'h00300 | p, 8'(p * 7), 16'h0000, "R2");
    end
    // R1: every port address under every switch value
    for (int s = 0; s < 16; s++) begin
      io_sw = 4'(s);
      for (int a = 0; a < 1024; a++)
        xfer(0, 20'(a), 8'h00, 16'((a * 40503) ^ (s << 12)), "R1");
    end
    io_sw = 4'h8;
    xfer(1, 20'h00300, 8'h00, 16'h0000, "R5");
    // R7: write pairs over every byte value
    for (int d = 0; d < 256; d++) begin
      xfer(1, 20'h00310, 8'(d), 16'h0000, "R7");
      xfer(1, 20'h00311, 8'(~d), 16'h0000, "R7");
    end
    // R6: read pairs with distinct halves
    for (int d = 0; d < 64; d++) begin
      xfer(0, 20'h00310, 8'h00, 16'((d * 1031) ^ 16'h5A3C), "R6");
      xfer(0, 20'h00311, 8'h00, 16'hFFFF, "R6");
    end
    // R8: every ROM base against every A19:A13 value
    for (int r = 0; r < 16; r++) begin
      rom_sw = 4'(r);
      for (int h = 0; h < 128; h++)
        xfer(2, {7'(h), 13'h0A5C}, 8'h00, 16'hFFFF, "R8");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule